// File: doc/BRIEF.md
# Transmit Interrupt Moderation Unit

This block decides when a transmit path raises its "descriptors written back" interrupt cause and its "descriptor ring running low" cause. It watches per-descriptor completion events, each carrying a report-status flag and a delay-enable flag. Completions that ask for a report but not for delay produce an interrupt at once. Completions that ask for both are coalesced by two countdowns running on a prescaled time tick. The relative countdown is pushed back by every such completion. The absolute countdown is armed once and is not pushed back, so it bounds the worst-case latency. Whichever interrupt comes first cancels both countdowns, so one burst of work produces one interrupt.

A separate detector compares the available-descriptor count with a threshold programmed in units of eight. It raises the low cause only on the exact one-step fall from eight times the threshold plus one down to eight times the threshold. Three configuration registers hold the absolute delay, the relative delay and the low threshold. They are written and read through a small select/data port.

Top module: `txint_moderator`

## Requirements
- R1: After reset all three configuration fields are zero. `cfg_sel` encodes 0 = absolute delay, 1 = relative delay, 2 = low threshold and 3 = nothing (writes ignored, reads zero). A write stores only the low DLY_W (delays) or LOW_W (threshold) bits of `cfg_wdata`, and every read bit above the field reads zero.
- R2: A completion with report-status 1 and delay-enable 0 drives `wbdone_irq` high in the cycle right after the completion cycle, back-to-back completions included.
- R3: A completion with report-status 0 never raises `wbdone_irq` and arms no countdown, whatever its delay-enable flag.
- R4: With a nonzero relative delay N, a completion with both flags set (re)loads the relative countdown with N. `wbdone_irq` rises in the cycle after the N-th tick that follows the most recent such completion. A tick in the same cycle as a completion is not counted.
- R5: With a relative delay of zero, a completion with both flags set is reported immediately, as in R2, and arms no countdown.
- R6: With a nonzero absolute delay M, the first completion with both flags set arms the absolute countdown with M, and later ones do not restart it. `wbdone_irq` rises in the cycle after the M-th tick even while the relative countdown keeps being reloaded.
- R7: An absolute delay of zero disables the absolute countdown.
- R8: Any interrupt (immediate, relative expiry or absolute expiry) cancels both countdowns, so no second interrupt follows without a new completion.
- R9: With threshold L nonzero, `desc_low_irq` is high for one cycle right after a cycle in which `avail_cnt` equals 8*L and, one cycle earlier, equalled 8*L+1. No other change of the count fires it.
- R10: A threshold of zero disables `desc_low_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | A descriptor completed this cycle |
| cmp_rs | input | 1 | Completion asks for a status report |
| cmp_ide | input | 1 | Completion asks for delayed reporting |
| tick | input | 1 | One pulse per delay time unit |
| avail_cnt | input | CNT_W | Descriptors currently available |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected configuration value, zero-extended |
| wbdone_irq | output | 1 | Write-back-done interrupt cause pulse |
| desc_low_irq | output | 1 | Descriptor-low interrupt cause pulse |

## Verification
The bench builds the block with DLY_W = 8, CNT_W = 10 and LOW_W = 4. With these widths, a write of all ones shows the truncation and zero-extension of every field. The largest threshold, 15, puts the low-water boundary at 121 to 120, which a 10-bit count can reach. Short delays of two to six ticks make it possible to count, cycle by cycle, the relative reload, the absolute expiry under constant reloads, and each cancellation path.

// File: rtl/txim_pkg.sv
package txim_pkg;

    typedef enum logic [1:0] {
        SEL_ABS  = 2'd0,
        SEL_REL  = 2'd1,
        SEL_LOW  = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

    localparam int unsigned RDATA_W = 32;

endpackage

// File: rtl/txim_countdown.sv
module txim_countdown #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         cancel_i,
    input  logic         tick_i,
    output logic         running_o,
    output logic         expire_o
);
    typedef struct packed {
        logic         run;
        logic [W-1:0] cnt;
    } cd_state_t;

    cd_state_t st_d, st_q;

    assign running_o = st_q.run;
    assign expire_o  = st_q.run & tick_i & (st_q.cnt == W'(1));

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.run = 1'b1;
            st_d.cnt = load_val_i;
        end else if (cancel_i || expire_o) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (st_q.run && tick_i) begin
            st_d.cnt = st_q.cnt - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_load_arms_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.run && st_q.cnt == $past(load_val_i)));

    assert_load_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (load_val_i != '0));

    assert_count_falls_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !load_i) |=> (st_q.cnt <= $past(st_q.cnt)));

    assert_expire_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !load_i) |=> !st_q.run);

endmodule

// File: rtl/txim_cfg.sv
module txim_cfg
    import txim_pkg::*;
#(
    parameter int unsigned DLY_W = 16,
    parameter int unsigned LOW_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [1:0]         sel_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    output logic [DLY_W-1:0]   abs_o,
    output logic [DLY_W-1:0]   rel_o,
    output logic [LOW_W-1:0]   low_o
);
    typedef struct packed {
        logic [DLY_W-1:0] abs_dly;
        logic [DLY_W-1:0] rel_dly;
        logic [LOW_W-1:0] low_thr;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    cfg_sel_e   sel;
    logic       unused_wdata;

    assign sel          = cfg_sel_e'(sel_i);
    assign unused_wdata = ^wdata_i;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            unique case (sel)
                SEL_ABS:  st_d.abs_dly = wdata_i[DLY_W-1:0];
                SEL_REL:  st_d.rel_dly = wdata_i[DLY_W-1:0];
                SEL_LOW:  st_d.low_thr = wdata_i[LOW_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ABS: rdata_o = RDATA_W'(st_q.abs_dly);
            SEL_REL: rdata_o = RDATA_W'(st_q.rel_dly);
            SEL_LOW: rdata_o = RDATA_W'(st_q.low_thr);
            default: rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign abs_o = st_q.abs_dly;
    assign rel_o = st_q.rel_dly;
    assign low_o = st_q.low_thr;

    assert_dly_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_ABS || sel == SEL_REL) |-> ((rdata_o >> DLY_W) == '0));

    assert_none_reads_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (rdata_o == '0));

    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel == SEL_REL) |=> (rel_o == $past(wdata_i[DLY_W-1:0])));

endmodule

// File: rtl/txim_lowwater.sv
module txim_lowwater #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] avail_i,
    input  logic [LOW_W-1:0] low_i,
    output logic             irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] prev;
        logic             irq;
    } lw_state_t;

    lw_state_t        st_d, st_q;
    logic [CNT_W-1:0] thr;
    logic [CNT_W-1:0] thr_p1;

    assign thr    = CNT_W'({low_i, 3'b000});
    assign thr_p1 = thr + CNT_W'(1);

    always_comb begin
        st_d      = st_q;
        st_d.prev = avail_i;
        st_d.irq  = (low_i != '0) && (avail_i == thr) && (st_q.prev == thr_p1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o = st_q.irq;

    assert_low_hits_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(avail_i) == $past(thr)));

    assert_low_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_low_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(low_i) == '0) |-> !irq_o);

endmodule

// File: rtl/txint_moderator.sv
module txint_moderator
    import txim_pkg::*;
#(
    parameter int unsigned DLY_W = 16,
    parameter int unsigned CNT_W = 16,
    parameter int unsigned LOW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_valid,
    input  logic             cmp_rs,
    input  logic             cmp_ide,
    input  logic             tick,
    input  logic [CNT_W-1:0] avail_cnt,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    output logic             wbdone_irq,
    output logic             desc_low_irq
);
    typedef struct packed {
        logic wb_irq;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic [DLY_W-1:0] abs_dly, rel_dly;
    logic [LOW_W-1:0] low_thr;
    logic             imm, qual, irq_now, rel_fire;
    logic             abs_load, abs_run, abs_exp;
    logic             rel_run, rel_exp;

    txim_cfg #(.DLY_W(DLY_W), .LOW_W(LOW_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .sel_i   (cfg_sel),
        .wdata_i (cfg_wdata),
        .rdata_o (cfg_rdata),
        .abs_o   (abs_dly),
        .rel_o   (rel_dly),
        .low_o   (low_thr)
    );

    // Event classification and the cancellation network
    always_comb begin
        imm      = cmp_valid & cmp_rs & (~cmp_ide | (rel_dly == '0));
        qual     = cmp_valid & cmp_rs & cmp_ide & (rel_dly != '0);
        rel_fire = rel_exp & ~qual;
        irq_now  = imm | rel_fire | abs_exp;
        abs_load = qual & (abs_dly != '0) & (~abs_run | irq_now);
        st_d        = st_q;
        st_d.wb_irq = irq_now;
    end

    txim_countdown #(.W(DLY_W)) u_rel_cd (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (qual),
        .load_val_i (rel_dly),
        .cancel_i   (irq_now),
        .tick_i     (tick),
        .running_o  (rel_run),
        .expire_o   (rel_exp)
    );

    txim_countdown #(.W(DLY_W)) u_abs_cd (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (abs_load),
        .load_val_i (abs_dly),
        .cancel_i   (irq_now),
        .tick_i     (tick),
        .running_o  (abs_run),
        .expire_o   (abs_exp)
    );

    txim_lowwater #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_lowwater (
        .clk     (clk),
        .rst_n   (rst_n),
        .avail_i (avail_cnt),
        .low_i   (low_thr),
        .irq_o   (desc_low_irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wbdone_irq = st_q.wb_irq;

    assert_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_rs && !cmp_ide) |=> wbdone_irq);

    assert_no_report_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && !cmp_rs && !rel_run && !abs_run) |=> !wbdone_irq);

    assert_rel_zero_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_rs && rel_dly == '0) |=> (wbdone_irq && !rel_run));

    assert_abs_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (abs_run && !irq_now) |=> abs_run);

    assert_cancel_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_now && !cmp_valid) |=> (!abs_run && !rel_run));

endmodule

// File: tb/txint_moderator_tb.sv
`timescale 1ns/1ps
module txint_moderator_tb;
    localparam int unsigned DLY_W = 8;
    localparam int unsigned CNT_W = 10;
    localparam int unsigned LOW_W = 4;

    typedef struct packed {
        logic [CNT_W-1:0] avail;
        logic             exp_low;
    } lw_vec_t;

    // Threshold 2 -> level 16; fires only on 17 -> 16
    localparam lw_vec_t LW_TAB [12] = '{
        '{10'd20, 1'b0}, '{10'd17, 1'b0}, '{10'd16, 1'b1}, '{10'd16, 1'b0},
        '{10'd15, 1'b0}, '{10'd17, 1'b0}, '{10'd16, 1'b1}, '{10'd18, 1'b0},
        '{10'd16, 1'b0}, '{10'd17, 1'b0}, '{10'd16, 1'b1}, '{10'd15, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmp_valid = 1'b0, cmp_rs = 1'b0, cmp_ide = 1'b0, tick = 1'b0;
    logic [CNT_W-1:0] avail_cnt = '0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_sel = 2'd0;
    logic [31:0]      cfg_wdata = '0;
    logic [31:0]      cfg_rdata;
    logic             wbdone_irq, desc_low_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    txint_moderator #(.DLY_W(DLY_W), .CNT_W(CNT_W), .LOW_W(LOW_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_rs(cmp_rs),
        .cmp_ide(cmp_ide), .tick(tick), .avail_cnt(avail_cnt), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .wbdone_irq(wbdone_irq), .desc_low_irq(desc_low_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: inputs held through the edge, outputs sampled 1 ns after it
    task automatic step(input bit t, input bit v, input bit rs, input bit ide);
        tick = t; cmp_valid = v; cmp_rs = rs; cmp_ide = ide;
        @(posedge clk); #1;
        tick = 1'b0; cmp_valid = 1'b0; cmp_rs = 1'b0; cmp_ide = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(posedge clk); #1;
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] sel, input logic [31:0] exp);
        cfg_sel = sel; #0.5;
        chk(req, cfg_rdata, exp);
    endtask

    task automatic ticks_quiet(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            step(1, 0, 0, 0);
            chk(req, {31'd0, wbdone_irq}, 32'd0);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step(0, 0, 0, 0);

        // R1 reset values and register map
        chk("R1 reset wbdone", {31'd0, wbdone_irq}, 32'd0);
        chk("R1 reset desc_low", {31'd0, desc_low_irq}, 32'd0);
        for (int s = 0; s < 4; s++) rd_chk("R1 reset read", 2'(s), 32'd0);
        wr(2'd0, 32'hFFFF_FFFF); rd_chk("R1 abs trunc", 2'd0, 32'h0000_00FF);
        wr(2'd1, 32'hFFFF_FF5A); rd_chk("R1 rel trunc", 2'd1, 32'h0000_005A);
        wr(2'd2, 32'hFFFF_FFFF); rd_chk("R1 low trunc", 2'd2, 32'h0000_000F);
        wr(2'd3, 32'h1234_5678); rd_chk("R1 none sel", 2'd3, 32'd0);
        rd_chk("R1 abs kept", 2'd0, 32'h0000_00FF);
        wr(2'd0, 0); wr(2'd1, 0); wr(2'd2, 0);

        // R9 low-water table walk
        wr(2'd2, 32'd2);
        foreach (LW_TAB[i]) begin
            avail_cnt = LW_TAB[i].avail;
            step(0, 0, 0, 0);
            chk($sformatf("R9 table step %0d", i), {31'd0, desc_low_irq}, {31'd0, LW_TAB[i].exp_low});
        end
        // R9 largest threshold boundary
        wr(2'd2, 32'd15);
        avail_cnt = 10'd121; step(0, 0, 0, 0);
        chk("R9 at 121", {31'd0, desc_low_irq}, 32'd0);
        avail_cnt = 10'd120; step(0, 0, 0, 0);
        chk("R9 121->120", {31'd0, desc_low_irq}, 32'd1);
        step(0, 0, 0, 0);
        chk("R9 single pulse", {31'd0, desc_low_irq}, 32'd0);
        // R10 disabled threshold
        wr(2'd2, 32'd0);
        avail_cnt = 10'd1; step(0, 0, 0, 0);
        avail_cnt = 10'd0; step(0, 0, 0, 0);
        chk("R10 1->0", {31'd0, desc_low_irq}, 32'd0);
        avail_cnt = 10'd9; step(0, 0, 0, 0);
        avail_cnt = 10'd8; step(0, 0, 0, 0);
        chk("R10 9->8", {31'd0, desc_low_irq}, 32'd0);

        // R4 relative countdown of 3
        wr(2'd1, 32'd3);
        step(0, 1, 1, 1); chk("R4 arm", {31'd0, wbdone_irq}, 32'd0);
        step(1, 0, 0, 0); chk("R4 tick1", {31'd0, wbdone_irq}, 32'd0);
        step(1, 0, 0, 0); chk("R4 tick2", {31'd0, wbdone_irq}, 32'd0);
        step(1, 0, 0, 0); chk("R4 tick3 fires", {31'd0, wbdone_irq}, 32'd1);
        ticks_quiet("R8 after rel expiry", 4);

        // R4 reload by a second completion
        step(0, 1, 1, 1);
        step(1, 0, 0, 0); step(1, 0, 0, 0);
        step(0, 1, 1, 1); chk("R4 reload", {31'd0, wbdone_irq}, 32'd0);
        step(1, 0, 0, 0); step(1, 0, 0, 0);
        chk("R4 reload pending", {31'd0, wbdone_irq}, 32'd0);
        step(1, 0, 0, 0); chk("R4 reload fires", {31'd0, wbdone_irq}, 32'd1);

        // R7 absolute disabled: constant reloads never interrupt
        for (int i = 0; i < 8; i++) begin
            step(1, 1, 1, 1);
            chk("R7 no absolute", {31'd0, wbdone_irq}, 32'd0);
        end
        step(1, 0, 0, 0); step(1, 0, 0, 0);
        step(1, 0, 0, 0); chk("R7 rel drains", {31'd0, wbdone_irq}, 32'd1);

        // R6 absolute bound of 5 under constant reloads
        wr(2'd0, 32'd5);
        step(0, 1, 1, 1);
        for (int i = 0; i < 4; i++) begin
            step(1, 1, 1, 1);
            chk("R6 not yet", {31'd0, wbdone_irq}, 32'd0);
        end
        step(1, 0, 0, 0); chk("R6 abs fires", {31'd0, wbdone_irq}, 32'd1);
        ticks_quiet("R8 abs cancels rel", 6);

        // R8 immediate cancels both
        step(0, 1, 1, 1);
        step(1, 0, 0, 0);
        step(0, 1, 1, 0); chk("R2 immediate", {31'd0, wbdone_irq}, 32'd1);
        ticks_quiet("R8 imm cancels", 8);

        // R8 relative expiry cancels absolute
        wr(2'd1, 32'd2); wr(2'd0, 32'd6);
        step(0, 1, 1, 1);
        step(1, 0, 0, 0); chk("R8 rel tick1", {31'd0, wbdone_irq}, 32'd0);
        step(1, 0, 0, 0); chk("R8 rel fires", {31'd0, wbdone_irq}, 32'd1);
        ticks_quiet("R8 abs cancelled", 8);

        // R5 relative zero: direct report, nothing armed
        wr(2'd1, 32'd0); wr(2'd0, 32'd4);
        step(0, 1, 1, 1); chk("R5 direct", {31'd0, wbdone_irq}, 32'd1);
        ticks_quiet("R5 nothing armed", 6);

        // R3 no report requested
        wr(2'd1, 32'd2); wr(2'd0, 32'd3);
        step(0, 1, 0, 1); chk("R3 rs0 ide1", {31'd0, wbdone_irq}, 32'd0);
        ticks_quiet("R3 nothing armed", 5);
        step(0, 1, 0, 0); chk("R3 rs0 ide0", {31'd0, wbdone_irq}, 32'd0);

        // R2 back-to-back immediates
        step(0, 1, 1, 0); chk("R2 first", {31'd0, wbdone_irq}, 32'd1);
        step(0, 1, 1, 0); chk("R2 second", {31'd0, wbdone_irq}, 32'd1);
        step(0, 0, 0, 0); chk("R2 idle", {31'd0, wbdone_irq}, 32'd0);

        summary();
    end
endmodule